// File: doc/BRIEF.md
# Doorbell Software Interrupt Unit

This unit holds 32 doorbell bits for each of several CPUs and turns them into interrupt requests. A CPU, or a message-signalled write arriving from a device, raises doorbells by sending one trigger word. That word names a doorbell number and a bitmap of target CPUs. The named doorbell is set in every CPU the bitmap selects. Each CPU owns a banked cause register, which records pending doorbells, and a mask register, which enables doorbells. Software clears pending doorbells with a write-zero-to-clear access. In that access a 0 bit clears its cause bit and a 1 bit keeps it.

For each CPU the unit drives two summary request lines. The low doorbell band (0 to 7) is used for inter-processor signalling and feeds the `ipi_req` line. The high band (16 to 31) is used for message-signalled interrupts and feeds the `msi_req` line. Doorbells 8 to 15 can be set and read back, but they drive neither line.

Triggers and register writes arrive on two separate valid/ready channels, so they can land in the same cycle. Both channels are always ready: a transfer happens on every rising clock edge where valid is high, and there is no back-pressure. The read port is a plain combinational lookup.

Top module: `doorbell_unit`

## Requirements
- R1: A trigger word carries the doorbell number in bits [7:0] and a target-CPU bitmap starting at bit 8, where bit 8+c selects CPU c. Each accepted trigger sets that doorbell's cause bit in every selected CPU, and the new value is visible from the next cycle.
- R2: A trigger whose doorbell number is 32 or more changes no cause register. Bitmap bits for CPUs that are not implemented (bit 8+c with c of 4 or more) are ignored.
- R3: The message-signalled trigger word 0xF00 | (16+n) sets doorbell 16+n in all four CPUs.
- R4: A register write to offset 0x08 addressed to CPU c clears each cause bit of that CPU where the data has a 0 and keeps each bit where the data has a 1. Writing 0 clears every pending doorbell.
- R5: A register write to offset 0x08+4 (0x0C) addressed to CPU c replaces that CPU's mask. A 1 enables the doorbell; writing 0 disables all doorbells.
- R6: `ipi_req[c]` is high exactly when at least one of doorbells 0 to 7 is both pending and enabled for CPU c.
- R7: `msi_req[c]` is high exactly when at least one of doorbells 16 to 31 is both pending and enabled for CPU c.
- R8: Doorbells 8 to 15 are stored in the cause register and read back, but contribute to neither request line.
- R9: When a trigger sets a cause bit in the same cycle that a cause write clears it, the bit ends up set.
- R10: Reset clears all cause and mask bits, so both request lines of every CPU are low.
- R11: The read port returns the cause register of `rd_cpu` at offset 0x08, its mask at 0x0C, and 0 at any other offset. Register writes to any other offset change nothing.
- R12: `trig_ready` and `reg_ready` are high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | A trigger word is offered |
| trig_ready | output | 1 | Trigger channel accepts (always 1) |
| trig_data | input | 32 | Trigger word: doorbell number [7:0], CPU bitmap from bit 8 |
| reg_valid | input | 1 | A per-CPU register write is offered |
| reg_ready | output | 1 | Register channel accepts (always 1) |
| reg_cpu | input | 2 | CPU whose banked register is written |
| reg_addr | input | 8 | Register offset (0x08 cause, 0x0C mask) |
| reg_data | input | 32 | Write data |
| rd_cpu | input | 2 | CPU whose banked register is read |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 32 | Read data (combinational) |
| ipi_req | output | 4 | Per-CPU summary of doorbells 0 to 7 |
| msi_req | output | 4 | Per-CPU summary of doorbells 16 to 31 |

## Verification
The hardest case to reach is a trigger and a write-zero clear hitting the same cause bit on the same clock edge. With a single bus this cannot happen, so the bench drives both channels valid in the same cycle. It does this once deliberately, with a clear-all to CPU 0 while doorbell 3 targets CPU 0, and many more times during a long random phase where both channels fire independently. The other cases that matter are doorbell numbers at or above 32, bitmap bits beyond the fourth CPU, and doorbells in the 8 to 15 band. Each of these is set up with directed trigger words, and the bench then reads back the cause registers and the request lines.

// File: rtl/db_pkg.sv
package db_pkg;

  localparam int DB_WORD_W  = 32;
  localparam int DB_NUM_W   = 8;
  localparam int DB_TGT_LSB = 8;

  localparam logic [7:0] OFS_CAUSE = 8'h08;
  localparam logic [7:0] OFS_MASK  = 8'h0C;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2
  } db_sel_e;

  function automatic db_sel_e db_decode_ofs(input logic [7:0] ofs);
    db_sel_e s;
    case (ofs)
      OFS_CAUSE: s = SEL_CAUSE;
      OFS_MASK:  s = SEL_MASK;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
  import db_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NDB  = 32,
  localparam int IDX_W = $clog2(NDB)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            trig_fire,
  input  logic [DB_WORD_W-1:0]            trig_word,
  output logic [NCPU-1:0][NDB-1:0]        set_vec
);

  logic [DB_NUM_W-1:0] num;
  logic                num_ok;
  logic [NDB-1:0]      onehot;

  assign num    = trig_word[DB_NUM_W-1:0];
  assign num_ok = (num < DB_NUM_W'(NDB));
  assign onehot = {{(NDB-1){1'b0}}, 1'b1} << num[IDX_W-1:0];

  for (genvar c = 0; c < NCPU; c++) begin : g_tgt
    logic hit;
    assign hit        = trig_fire && num_ok && trig_word[DB_TGT_LSB + c];
    assign set_vec[c] = hit ? onehot : '0;

    assert_single_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec[c]));
  end

endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank #(
  parameter int NDB = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NDB-1:0] set_vec,
  input  logic           clr_en,
  input  logic [NDB-1:0] clr_keep,
  input  logic           mask_we,
  input  logic [NDB-1:0] mask_wdata,
  output logic [NDB-1:0] cause,
  output logic [NDB-1:0] mask
);

  logic [NDB-1:0] cause_kept;

  assign cause_kept = clr_en ? (cause & clr_keep) : cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '0;
    end else begin
      cause <= cause_kept | set_vec;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));

  assert_no_spurious_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & ~$past(cause) & ~$past(set_vec)) == '0);

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ((set_vec & ~clr_keep) != '0)) |=> ((cause & $past(set_vec)) != '0));

  assert_clear_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_vec == '0) |=> (cause == ($past(cause) & $past(clr_keep))));

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(mask_wdata)));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask));

endmodule

// File: rtl/db_summary.sv
module db_summary #(
  parameter int NDB = 32,
  parameter int LO  = 0,
  parameter int HI  = 7
) (
  input  logic [NDB-1:0] cause,
  input  logic [NDB-1:0] mask,
  output logic           req
);

  logic [NDB-1:0] band;

  for (genvar b = 0; b < NDB; b++) begin : g_band
    if (b >= LO && b <= HI) begin : g_in
      assign band[b] = 1'b1;
    end else begin : g_out
      assign band[b] = 1'b0;
    end
  end

  assign req = |(cause & mask & band);

endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import db_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NDB    = 32,
  parameter int IPI_LO = 0,
  parameter int IPI_HI = 7,
  parameter int MSI_LO = 16,
  parameter int MSI_HI = 31,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_valid,
  output logic                 trig_ready,
  input  logic [DB_WORD_W-1:0] trig_data,
  input  logic                 reg_valid,
  output logic                 reg_ready,
  input  logic [CPU_W-1:0]     reg_cpu,
  input  logic [7:0]           reg_addr,
  input  logic [NDB-1:0]       reg_data,
  input  logic [CPU_W-1:0]     rd_cpu,
  input  logic [7:0]           rd_addr,
  output logic [NDB-1:0]       rd_data,
  output logic [NCPU-1:0]      ipi_req,
  output logic [NCPU-1:0]      msi_req
);

  logic                     trig_fire;
  logic                     reg_fire;
  db_sel_e                  wr_sel;
  db_sel_e                  rd_sel;
  logic [NCPU-1:0][NDB-1:0] set_vec;
  logic [NDB-1:0]           cause_a [NCPU];
  logic [NDB-1:0]           mask_a  [NCPU];
  logic [NCPU*NDB-1:0]      cause_flat;

  assign trig_ready = 1'b1;
  assign reg_ready  = 1'b1;
  assign trig_fire  = trig_valid && trig_ready;
  assign reg_fire   = reg_valid && reg_ready;
  assign wr_sel     = db_decode_ofs(reg_addr);
  assign rd_sel     = db_decode_ofs(rd_addr);

  db_trig_decode #(.NCPU(NCPU), .NDB(NDB)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_fire (trig_fire),
    .trig_word (trig_data),
    .set_vec   (set_vec)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic me;
    assign me = reg_fire && (reg_cpu == CPU_W'(c));

    db_cpu_bank #(.NDB(NDB)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec[c]),
      .clr_en     (me && wr_sel == SEL_CAUSE),
      .clr_keep   (reg_data),
      .mask_we    (me && wr_sel == SEL_MASK),
      .mask_wdata (reg_data),
      .cause      (cause_a[c]),
      .mask       (mask_a[c])
    );

    db_summary #(.NDB(NDB), .LO(IPI_LO), .HI(IPI_HI)) u_ipi (
      .cause (cause_a[c]),
      .mask  (mask_a[c]),
      .req   (ipi_req[c])
    );

    db_summary #(.NDB(NDB), .LO(MSI_LO), .HI(MSI_HI)) u_msi (
      .cause (cause_a[c]),
      .mask  (mask_a[c]),
      .req   (msi_req[c])
    );

    assign cause_flat[c*NDB +: NDB] = cause_a[c];

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_a[c] == '0) |-> (!ipi_req[c] && !msi_req[c]));

    assert_mid_band_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((cause_a[c] & mask_a[c]) >> (IPI_HI + 1)) << (IPI_HI + 1) ==
       (cause_a[c] & mask_a[c]) &&
       ((cause_a[c] & mask_a[c]) >> MSI_LO) == '0)
      |-> (!ipi_req[c] && !msi_req[c]));
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (rd_cpu == CPU_W'(c)) begin
        case (rd_sel)
          SEL_CAUSE: rd_data = cause_a[c];
          SEL_MASK:  rd_data = mask_a[c];
          default:   rd_data = '0;
        endcase
      end
    end
  end

  assert_oob_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_data[DB_NUM_W-1:0] >= DB_NUM_W'(NDB) && !reg_valid)
    |=> $stable(cause_flat));

endmodule

// File: tb/sim_doorbell_unit.sv
module sim_doorbell_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [31:0] trig_data = '0;
  logic        reg_valid = 1'b0;
  logic        reg_ready;
  logic [1:0]  reg_cpu = '0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_data = '0;
  logic [1:0]  rd_cpu = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  ipi_req;
  logic [3:0]  msi_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_cause [4];
  logic [31:0] m_mask  [4];

  always #10 clk = ~clk;

  doorbell_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_data(trig_data),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_cpu(reg_cpu),
    .reg_addr(reg_addr), .reg_data(reg_data),
    .rd_cpu(rd_cpu), .rd_addr(rd_addr), .rd_data(rd_data),
    .ipi_req(ipi_req), .msi_req(msi_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Reference model: clear-then-set per CPU, evaluated on every clock edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cause[c] <= '0;
        m_mask[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] nx;
        nx = m_cause[c];
        if (reg_valid && reg_cpu == 2'(c) && reg_addr == 8'h08) nx = nx & reg_data;
        if (trig_valid && trig_data[8+c] && trig_data[7:0] < 8'd32)
          nx = nx | (32'h1 << trig_data[4:0]);
        m_cause[c] <= nx;
        if (reg_valid && reg_cpu == 2'(c) && reg_addr == 8'h0C) m_mask[c] <= reg_data;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] c, input logic [7:0] a);
    if (a == 8'h08) return m_cause[c];
    if (a == 8'h0C) return m_mask[c];
    return 32'h0;
  endfunction

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++) begin
        chk("R6 model ipi_req", 32'(ipi_req[c]), 32'(|(m_cause[c] & m_mask[c] & 32'h0000_00FF)));
        chk("R7 model msi_req", 32'(msi_req[c]), 32'(|(m_cause[c] & m_mask[c] & 32'hFFFF_0000)));
      end
      chk("R11 model rd_data", rd_data, exp_rd(rd_cpu, rd_addr));
    end
  end

  task automatic put(input logic tv, input logic [31:0] td,
                     input logic rv, input logic [1:0] rc,
                     input logic [7:0] ra, input logic [31:0] rdv);
    @(negedge clk); #1;
    trig_valid = tv; trig_data = td;
    reg_valid = rv; reg_cpu = rc; reg_addr = ra; reg_data = rdv;
    @(negedge clk); #1;
    trig_valid = 1'b0; reg_valid = 1'b0;
  endtask

  task automatic trig(input logic [31:0] w);
    put(1'b1, w, 1'b0, 2'd0, 8'h00, 32'h0);
  endtask

  task automatic wreg(input logic [1:0] c, input logic [7:0] a, input logic [31:0] d);
    put(1'b0, 32'h0, 1'b1, c, a, d);
  endtask

  task automatic rdreg(input logic [1:0] c, input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); #2;
    rd_cpu = c; rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wrap_up;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    wrap_up();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R10: reset state
    for (int c = 0; c < 4; c++) begin
      rdreg(2'(c), 8'h08, v); chk("R10 cause after reset", v, 32'h0);
      rdreg(2'(c), 8'h0C, v); chk("R10 mask after reset", v, 32'h0);
    end
    chk("R10 ipi_req in reset", 32'(ipi_req), 32'h0);
    chk("R10 msi_req in reset", 32'(msi_req), 32'h0);
    @(negedge clk); #1 rst_n = 1'b1;

    // R12
    chk("R12 trig_ready", 32'(trig_ready), 32'h1);
    chk("R12 reg_ready", 32'(reg_ready), 32'h1);

    // R5: enable IPI and MSI bands
    for (int c = 0; c < 4; c++) wreg(2'(c), 8'h0C, 32'hFFFF_00FF);
    rdreg(2'd3, 8'h0C, v); chk("R5 mask readback", v, 32'hFFFF_00FF);

    // R1: doorbell 3 to CPUs 0 and 2
    trig(32'h0000_0503);
    rdreg(2'd0, 8'h08, v); chk("R1 cpu0 cause", v, 32'h0000_0008);
    rdreg(2'd1, 8'h08, v); chk("R1 cpu1 untouched", v, 32'h0);
    rdreg(2'd2, 8'h08, v); chk("R1 cpu2 cause", v, 32'h0000_0008);
    chk("R6 ipi_req after trigger", 32'(ipi_req), 32'h5);

    // R3: message-signalled word for n=5
    trig(32'h0000_0F15);
    rdreg(2'd0, 8'h08, v); chk("R3 cpu0 cause", v, 32'h0020_0008);
    rdreg(2'd3, 8'h08, v); chk("R3 cpu3 cause", v, 32'h0020_0000);
    chk("R7 msi_req all", 32'(msi_req), 32'hF);

    // R2: bitmap only above implemented CPUs, and doorbell 32
    trig(32'h0000_F00A);
    rdreg(2'd1, 8'h08, v); chk("R2 high bitmap ignored", v, 32'h0020_0000);
    trig(32'h0000_0F20);
    rdreg(2'd0, 8'h08, v); chk("R2 doorbell 32 ignored", v, 32'h0020_0008);
    chk("R2 ipi_req unchanged", 32'(ipi_req), 32'h5);

    // R8: doorbell 9 is stored but silent
    trig(32'h0000_0209);
    rdreg(2'd1, 8'h08, v); chk("R8 mid band stored", v, 32'h0020_0200);
    chk("R8 ipi_req cpu1 low", 32'(ipi_req[1]), 32'h0);

    // R4: write-zero clears only bit 21
    wreg(2'd1, 8'h08, 32'hFFDF_FFFF);
    rdreg(2'd1, 8'h08, v); chk("R4 clear one bit", v, 32'h0000_0200);
    chk("R8 msi_req cpu1 low", 32'(msi_req[1]), 32'h0);

    // R9: trigger and clear-all on cpu0 in the same cycle
    put(1'b1, 32'h0000_0103, 1'b1, 2'd0, 8'h08, 32'h0);
    rdreg(2'd0, 8'h08, v); chk("R9 set wins over clear", v, 32'h0000_0008);
    chk("R9 msi_req cpu0 low", 32'(msi_req[0]), 32'h0);

    // R4: clear all
    wreg(2'd2, 8'h08, 32'h0);
    rdreg(2'd2, 8'h08, v); chk("R4 clear all", v, 32'h0);
    chk("R6 ipi_req cpu2 low", 32'(ipi_req[2]), 32'h0);

    // R5: mask 0 silences, cause kept
    wreg(2'd0, 8'h0C, 32'h0);
    chk("R5 masked ipi_req low", 32'(ipi_req[0]), 32'h0);
    rdreg(2'd0, 8'h08, v); chk("R5 cause kept when masked", v, 32'h0000_0008);
    wreg(2'd0, 8'h0C, 32'h0000_00FF);
    chk("R6 re-enabled ipi_req", 32'(ipi_req[0]), 32'h1);

    // R11: other offsets
    wreg(2'd3, 8'h10, 32'h0);
    rdreg(2'd3, 8'h08, v); chk("R11 stray write cause", v, 32'h0020_0000);
    rdreg(2'd3, 8'h0C, v); chk("R11 stray write mask", v, 32'hFFFF_00FF);
    rdreg(2'd3, 8'h04, v); chk("R11 other offset reads 0", v, 32'h0);

    // Random traffic, compared against the model every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      trig_valid = ($urandom % 3) == 0;
      trig_data  = {16'h0, 8'($urandom), 8'($urandom % 40)};
      reg_valid  = ($urandom % 3) == 0;
      reg_cpu    = 2'($urandom);
      case ($urandom % 4)
        0: reg_addr = 8'h08;
        1: reg_addr = 8'h0C;
        2: reg_addr = 8'h04;
        default: reg_addr = 8'h10;
      endcase
      reg_data   = (reg_addr == 8'h08) ? ($urandom | $urandom | $urandom) : $urandom;
      rd_cpu     = 2'($urandom);
      rd_addr    = (($urandom % 2) == 0) ? 8'h08 : 8'h0C;
    end
    @(negedge clk); #1 trig_valid = 1'b0; reg_valid = 1'b0;
    repeat (2) @(negedge clk);
    #2 wrap_up();
  end

endmodule